// File: doc/BRIEF.md
# Half-Bridge Fault Latch and Status Reset Manager

This block sits between the analog fault comparators of a multi-channel half-bridge driver and its output controller. It takes raw per-channel overcurrent and underload flags, plus global thermal-warning, thermal-shutdown, undervoltage and overvoltage flags. It qualifies the channel faults with delay timers and keeps latched and self-clearing status. From that state it decides, on every clock, which channels may drive and in which direction. It also packs a 16-bit status word for the channel group that the last command selected.

Commands arrive as a one-cycle commit pulse when chip select rises at the end of a serial frame. Each commit carries the channel enables, the high/low configuration, the group select, the underload-shutdown enable, the overvoltage-lockout enable and an optional status-reset request. A status reset clears latched faults only in the group named in that command. It also clears the global thermal-shutdown latch. A second reset that comes too soon after an accepted one is dropped and reported on a flag.

Top module: `fault_status_mgr`

## Requirements
- R1: After reset, the status word, `drive_on`, `drive_hi`, `tsd_flag` and `srr_ignored` are all zero.
- R2: Overcurrent on a channel latches only if it is sampled high on OC_DLY consecutive clock edges. A shorter burst leaves no trace.
- R3: A latched overcurrent turns its channel off. It sets status bit 15 while that channel lies in the selected group, and it clears the channel's output-status bit.
- R4: A single global underload timer runs while any channel shows underload. A channel that joins later inherits the remaining time, so all underloaded channels qualify on the same edge.
- R5: A qualified underload always latches status bit 13. It turns channels off only when the underload-shutdown bit is 1, and then only those channels in the selected group.
- R6: A thermal-shutdown pulse latches `tsd_flag` and turns off every channel until an accepted status reset clears it.
- R7: Supply fail (bit 14) and thermal warning (bit 0) follow their inputs and clear on their own.
- R8: Undervoltage always forces every output off. Overvoltage forces outputs off only when the overvoltage-lockout command bit is 1, but it sets bit 14 in both cases.
- R9: An accepted status reset clears latched overcurrent and underload state only in the channels of its own group (group 0 = channels 0..GRP0-1, group 1 = the rest). It also clears the thermal-shutdown latch.
- R10: If a fault is still present when a status reset is accepted, the fault latches again straight away, and the channel stays off.
- R11: A status reset is accepted only if at least SRR_GAP cycles have passed since the last accepted one. Otherwise it is ignored, and `srr_ignored` pulses for one cycle.
- R12: Status word layout: bit 15 overcurrent, bit 14 supply fail, bit 13 underload, bits 12:7 output status and bits 6:1 high-side status of the group's channels (lowest channel at the lowest bit), bit 0 thermal warning. Bits with no channel read 0, and high-side status is 0 for any channel that is not driving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| oc_raw | input | NCH | Raw overcurrent flag per channel |
| ul_raw | input | NCH | Raw underload flag per channel |
| tw_raw | input | 1 | Thermal warning |
| tsd_raw | input | 1 | Thermal shutdown |
| uv_raw | input | 1 | Supply undervoltage |
| ov_raw | input | 1 | Supply overvoltage |
| cmd_commit | input | 1 | One-cycle pulse: command frame accepted |
| cmd_srr | input | 1 | Status-reset request in this command |
| cmd_grp | input | 1 | Channel group select |
| cmd_ul_sd | input | 1 | Underload shutdown enable |
| cmd_ov_lock | input | 1 | Overvoltage lockout enable |
| cmd_en | input | NCH | Channel enables |
| cmd_cfg | input | NCH | Channel direction, 1 = high side on |
| drive_on | output | NCH | Channel is actively driven |
| drive_hi | output | NCH | High side on (else low side) for driven channels |
| status_word | output | 16 | Packed status of the selected group |
| tsd_flag | output | 1 | Latched thermal shutdown |
| srr_ignored | output | 1 | Status reset dropped by the rate limit |

## Verification
The self-clearing bits (supply fail, thermal warning) and the lockout of the outputs register one edge after the input is sampled. A latched fault sets its latch on the qualifying edge and reaches `status_word`, `drive_on` and `tsd_flag` one edge later. Overcurrent therefore appears after OC_DLY+1 edges, and the bench checks that it is still absent after OC_DLY edges. A command takes one edge to register its fields and one more to reach the outputs. `srr_ignored` is valid right after the commit edge. The bench samples 1 ns after each rising edge and counts edges from the moment it drives a stimulus, so every check lands on the first cycle the result is due.

// File: rtl/fl_pkg.sv
`timescale 1ns/1ps
package fl_pkg;
  localparam int STW      = 16;
  localparam int FIELD_W  = 6;
  localparam int B_OC     = 15;
  localparam int B_PSF    = 14;
  localparam int B_UL     = 13;
  localparam int B_ST_LO  = 7;
  localparam int B_CF_LO  = 1;
  localparam int B_TW     = 0;
  typedef logic [STW-1:0] status_t;
endpackage

// File: rtl/fl_oc_qual.sv
`timescale 1ns/1ps
module fl_oc_qual #(
  parameter int DLY = 2500
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  input  logic clr,
  output logic lat_o
);
  localparam int CW = $clog2(DLY + 1);
  localparam logic [CW-1:0] LAST = CW'(DLY - 1);

  logic [CW-1:0] cnt;
  logic          trip;

  assign trip = raw && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (!raw) cnt <= '0;
    else if (!trip) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)       lat_o <= 1'b0;
    else if (clr)  lat_o <= 1'b0;
    else if (trip) lat_o <= 1'b1;
  end

  assert_oc_needs_raw_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(lat_o) |-> $past(raw));
  assert_oc_clear_R9: assert property (@(posedge clk) disable iff (rst)
    clr |=> !lat_o);
endmodule

// File: rtl/fl_ul_qual.sv
`timescale 1ns/1ps
module fl_ul_qual #(
  parameter int NCH = 8,
  parameter int DLY = 35000
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] raw,
  input  logic           sd_en,
  input  logic [NCH-1:0] gmask,
  input  logic [NCH-1:0] clr_mask,
  output logic [NCH-1:0] lat_o,
  output logic [NCH-1:0] off_o
);
  localparam int CW = $clog2(DLY + 1);
  localparam logic [CW-1:0] LAST = CW'(DLY - 1);

  logic [CW-1:0] cnt;
  logic          any_ul;
  logic          qual;

  assign any_ul = |raw;
  assign qual   = any_ul && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (!any_ul) cnt <= '0;
    else if (!qual)   cnt <= cnt + 1'b1;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        lat_o[i] <= 1'b0;
        off_o[i] <= 1'b0;
      end else if (clr_mask[i]) begin
        lat_o[i] <= 1'b0;
        off_o[i] <= 1'b0;
      end else begin
        if (qual && raw[i])                     lat_o[i] <= 1'b1;
        if (qual && raw[i] && sd_en && gmask[i]) off_o[i] <= 1'b1;
      end
    end

    assert_ul_sd_gate_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(off_o[i]) |-> $past(sd_en));
    assert_ul_off_has_status_R5: assert property (@(posedge clk) disable iff (rst)
      off_o[i] |-> lat_o[i]);
  end
endmodule

// File: rtl/fl_srr_gate.sv
`timescale 1ns/1ps
module fl_srr_gate #(
  parameter int GAP = 15000
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic accept_o,
  output logic ignored_o
);
  localparam int CW = $clog2(GAP + 1);
  localparam logic [CW-1:0] RELOAD = CW'(GAP - 1);

  logic [CW-1:0] cnt;
  logic          idle;

  assign idle     = (cnt == '0);
  assign accept_o = req && idle;

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (accept_o) cnt <= RELOAD;
    else if (!idle)    cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) ignored_o <= 1'b0;
    else     ignored_o <= req && !idle;
  end

  assert_ignore_needs_req_R11: assert property (@(posedge clk) disable iff (rst)
    ignored_o |-> $past(req));
endmodule

// File: rtl/fl_status_pack.sv
`timescale 1ns/1ps
module fl_status_pack
  import fl_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int GRP0 = 6
) (
  input  logic           grp,
  input  logic [NCH-1:0] gmask,
  input  logic [NCH-1:0] oc_lat,
  input  logic [NCH-1:0] ul_lat,
  input  logic           psf,
  input  logic           tw,
  input  logic [NCH-1:0] on_n,
  input  logic [NCH-1:0] hi_n,
  output status_t        word_o
);
  logic [FIELD_W-1:0] st_f;
  logic [FIELD_W-1:0] cf_f;

  for (genvar k = 0; k < FIELD_W; k++) begin : g_fld
    localparam int IA = k;
    localparam int IB = GRP0 + k;
    logic a_on, a_hi, b_on, b_hi;
    if (IA < GRP0) begin : g_a
      assign a_on = on_n[IA];
      assign a_hi = hi_n[IA];
    end else begin : g_a0
      assign a_on = 1'b0;
      assign a_hi = 1'b0;
    end
    if (IB < NCH) begin : g_b
      assign b_on = on_n[IB];
      assign b_hi = hi_n[IB];
    end else begin : g_b0
      assign b_on = 1'b0;
      assign b_hi = 1'b0;
    end
    assign st_f[k] = grp ? b_on : a_on;
    assign cf_f[k] = grp ? b_hi : a_hi;
  end

  always_comb begin
    word_o          = '0;
    word_o[B_OC]    = |(oc_lat & gmask);
    word_o[B_PSF]   = psf;
    word_o[B_UL]    = |(ul_lat & gmask);
    word_o[B_ST_LO +: FIELD_W] = st_f;
    word_o[B_CF_LO +: FIELD_W] = cf_f;
    word_o[B_TW]    = tw;
  end
endmodule

// File: rtl/fault_status_mgr.sv
`timescale 1ns/1ps
module fault_status_mgr
  import fl_pkg::*;
#(
  parameter int NCH     = 8,
  parameter int GRP0    = 6,
  parameter int OC_DLY  = 2500,
  parameter int UL_DLY  = 35000,
  parameter int SRR_GAP = 15000
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] oc_raw,
  input  logic [NCH-1:0] ul_raw,
  input  logic           tw_raw,
  input  logic           tsd_raw,
  input  logic           uv_raw,
  input  logic           ov_raw,
  input  logic           cmd_commit,
  input  logic           cmd_srr,
  input  logic           cmd_grp,
  input  logic           cmd_ul_sd,
  input  logic           cmd_ov_lock,
  input  logic [NCH-1:0] cmd_en,
  input  logic [NCH-1:0] cmd_cfg,
  output logic [NCH-1:0] drive_on,
  output logic [NCH-1:0] drive_hi,
  output logic [STW-1:0] status_word,
  output logic           tsd_flag,
  output logic           srr_ignored
);
  logic [NCH-1:0] en_r, cfg_r;
  logic           grp_r, sd_r, ovl_r;
  logic           tsd_lat;
  logic [NCH-1:0] gmask_cur, gmask_cmd, clr_mask;
  logic [NCH-1:0] oc_lat, ul_lat, ul_off;
  logic [NCH-1:0] off_n, on_n, hi_n;
  logic           srr_acc, lockout, psf;
  status_t        word_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_r  <= '0;
      cfg_r <= '0;
      grp_r <= 1'b0;
      sd_r  <= 1'b0;
      ovl_r <= 1'b0;
    end else if (cmd_commit) begin
      en_r  <= cmd_en;
      cfg_r <= cmd_cfg;
      grp_r <= cmd_grp;
      sd_r  <= cmd_ul_sd;
      ovl_r <= cmd_ov_lock;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_mask
    localparam bit IN_B = (i >= GRP0);
    assign gmask_cur[i] = grp_r   ? IN_B : !IN_B;
    assign gmask_cmd[i] = cmd_grp ? IN_B : !IN_B;
  end

  fl_srr_gate #(.GAP(SRR_GAP)) u_gate (
    .clk      (clk),
    .rst      (rst),
    .req      (cmd_commit && cmd_srr),
    .accept_o (srr_acc),
    .ignored_o(srr_ignored)
  );

  assign clr_mask = srr_acc ? gmask_cmd : '0;

  for (genvar i = 0; i < NCH; i++) begin : g_oc
    fl_oc_qual #(.DLY(OC_DLY)) u_oc (
      .clk  (clk),
      .rst  (rst),
      .raw  (oc_raw[i]),
      .clr  (clr_mask[i]),
      .lat_o(oc_lat[i])
    );
  end

  fl_ul_qual #(.NCH(NCH), .DLY(UL_DLY)) u_ul (
    .clk     (clk),
    .rst     (rst),
    .raw     (ul_raw),
    .sd_en   (sd_r),
    .gmask   (gmask_cur),
    .clr_mask(clr_mask),
    .lat_o   (ul_lat),
    .off_o   (ul_off)
  );

  always_ff @(posedge clk) begin
    if (rst)          tsd_lat <= 1'b0;
    else if (srr_acc) tsd_lat <= 1'b0;
    else if (tsd_raw) tsd_lat <= 1'b1;
  end

  assign lockout = uv_raw || (ov_raw && ovl_r);
  assign psf     = uv_raw || ov_raw;
  assign off_n   = oc_lat | ul_off | {NCH{tsd_lat}};
  assign on_n    = lockout ? '0 : (en_r & ~off_n);
  assign hi_n    = on_n & cfg_r;

  fl_status_pack #(.NCH(NCH), .GRP0(GRP0)) u_pack (
    .grp   (grp_r),
    .gmask (gmask_cur),
    .oc_lat(oc_lat),
    .ul_lat(ul_lat),
    .psf   (psf),
    .tw    (tw_raw),
    .on_n  (on_n),
    .hi_n  (hi_n),
    .word_o(word_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_on    <= '0;
      drive_hi    <= '0;
      status_word <= '0;
      tsd_flag    <= 1'b0;
    end else begin
      drive_on    <= on_n;
      drive_hi    <= hi_n;
      status_word <= word_n;
      tsd_flag    <= tsd_lat;
    end
  end

  assert_uv_lock_R8: assert property (@(posedge clk) disable iff (rst)
    uv_raw |=> (drive_on == '0));
  assert_tsd_off_R6: assert property (@(posedge clk) disable iff (rst)
    tsd_lat |=> (drive_on == '0));
  assert_srr_clears_tsd_R9: assert property (@(posedge clk) disable iff (rst)
    srr_acc |=> !tsd_lat);
  assert_cfg_masked_R12: assert property (@(posedge clk) disable iff (rst)
    (drive_hi & ~drive_on) == '0);
  assert_oc_forces_off_R3: assert property (@(posedge clk) disable iff (rst)
    (oc_lat != '0) |=> ((drive_on & $past(oc_lat)) == '0));
endmodule

// File: tb/sim_fault_status_mgr.sv
`timescale 1ns/1ps
module sim_fault_status_mgr;
  localparam int NCH = 8;
  localparam int GRP0 = 6;
  localparam int P_OC = 8;
  localparam int P_UL = 16;
  localparam int P_GAP = 20;
  localparam int NVEC = 7;

  // fields: en, cfg, grp, uv, ov, ovl, tw, expected status
  localparam logic [36:0] VEC [NVEC] = '{
    {8'h3F, 8'h15, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h1FAA},
    {8'hC0, 8'h40, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0182},
    {8'hFF, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 16'h4000},
    {8'hFF, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h5FFE},
    {8'hFF, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'h4000},
    {8'h0F, 8'hF0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0781},
    {8'hFF, 8'h81, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0184}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0] oc_raw = '0, ul_raw = '0, cmd_en = '0, cmd_cfg = '0;
  logic tw_raw = 0, tsd_raw = 0, uv_raw = 0, ov_raw = 0;
  logic cmd_commit = 0, cmd_srr = 0, cmd_grp = 0, cmd_ul_sd = 0, cmd_ov_lock = 0;
  logic [NCH-1:0] drive_on, drive_hi;
  logic [15:0] status_word;
  logic tsd_flag, srr_ignored;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fault_status_mgr #(.NCH(NCH), .GRP0(GRP0), .OC_DLY(P_OC), .UL_DLY(P_UL),
                     .SRR_GAP(P_GAP)) u0 (
    .clk(clk), .rst(rst), .oc_raw(oc_raw), .ul_raw(ul_raw), .tw_raw(tw_raw),
    .tsd_raw(tsd_raw), .uv_raw(uv_raw), .ov_raw(ov_raw), .cmd_commit(cmd_commit),
    .cmd_srr(cmd_srr), .cmd_grp(cmd_grp), .cmd_ul_sd(cmd_ul_sd),
    .cmd_ov_lock(cmd_ov_lock), .cmd_en(cmd_en), .cmd_cfg(cmd_cfg),
    .drive_on(drive_on), .drive_hi(drive_hi), .status_word(status_word),
    .tsd_flag(tsd_flag), .srr_ignored(srr_ignored));

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] en, input logic [7:0] cfg, input logic grp,
                      input logic srr, input logic sd, input logic ovl);
    cmd_en = en; cmd_cfg = cfg; cmd_grp = grp; cmd_srr = srr;
    cmd_ul_sd = sd; cmd_ov_lock = ovl; cmd_commit = 1'b1;
    tick(1);
    cmd_commit = 1'b0; cmd_srr = 1'b0;
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_up();
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    chk("R1 status", status_word, 0);
    chk("R1 drive_on", drive_on, 0);
    chk("R1 drive_hi", drive_hi, 0);
    chk("R1 tsd_flag", tsd_flag, 0);
    chk("R1 srr_ignored", srr_ignored, 0);

    // R12 R7 R8 packing and supply vectors
    for (int i = 0; i < NVEC; i++) begin
      logic [36:0] v;
      v = VEC[i];
      uv_raw = v[19]; ov_raw = v[18]; tw_raw = v[16];
      send(v[36:29], v[28:21], v[20], 1'b0, 1'b0, v[17]);
      tick(1);
      chk($sformatf("R12 R8 vector %0d", i), status_word, v[15:0]);
    end
    uv_raw = 0; ov_raw = 0; tw_raw = 0;
    tick(1);
    chk("R7 auto clear psf/tw", {status_word[14], status_word[0]}, 0);

    send(8'hFF, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    tick(1);
    chk("R12 baseline drive_on", drive_on, 8'hFF);

    // R2 short burst ignored
    oc_raw = 8'h04;
    tick(P_OC - 1);
    oc_raw = 8'h00;
    tick(3);
    chk("R2 short burst status", status_word[15], 0);
    chk("R2 short burst drive", drive_on, 8'hFF);

    // R2 R3 qualified overcurrent
    oc_raw = 8'h04;
    tick(P_OC);
    chk("R2 not yet latched", status_word[15], 0);
    tick(1);
    chk("R3 oc status", status_word[15], 1);
    chk("R3 channel off", drive_on, 8'hFB);
    chk("R3 output status bit", status_word[9], 0);

    // R10 reset while fault persists
    send(8'hFF, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    tick(3);
    chk("R10 relatched status", status_word[15], 1);
    chk("R10 relatched drive", drive_on, 8'hFB);
    oc_raw = 8'h00;
    tick(P_GAP + 5);
    send(8'hFF, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    tick(1);
    chk("R9 cleared status", status_word[15], 0);
    chk("R9 cleared drive", drive_on, 8'hFF);

    // R9 reset scoped to group
    oc_raw = 8'h80;
    tick(P_OC + 2);
    oc_raw = 8'h00;
    chk("R3 ch7 off", drive_on, 8'h7F);
    tick(P_GAP + 5);
    send(8'hFF, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    tick(1);
    chk("R9 other group kept", drive_on, 8'h7F);
    send(8'hFF, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0);
    tick(1);
    chk("R9 R12 group1 word", status_word, 16'h8080);

    // R11 rate limit
    send(8'hFF, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R11 ignored flag", srr_ignored, 1);
    tick(1);
    chk("R11 ignored flag drops", srr_ignored, 0);
    chk("R11 latch kept", status_word, 16'h8080);
    tick(P_GAP + 5);
    send(8'hFF, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0);
    chk("R11 accepted no flag", srr_ignored, 0);
    tick(1);
    chk("R9 group1 cleared drive", drive_on, 8'hFF);
    chk("R9 group1 cleared word", status_word, 16'h0180);

    // R4 R5 shared underload timer with shutdown
    send(8'hFF, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
    ul_raw = 8'h01;
    tick(P_UL / 2);
    ul_raw = 8'h03;
    tick(P_UL - P_UL / 2);
    chk("R4 not yet", status_word[13], 0);
    chk("R4 drive before", drive_on, 8'hFF);
    tick(1);
    chk("R4 ul status", status_word[13], 1);
    chk("R5 R4 both off together", drive_on, 8'hFC);
    ul_raw = 8'h00;

    // R5 no shutdown when disabled
    tick(P_GAP + 5);
    send(8'hFF, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    tick(1);
    chk("R9 ul cleared", drive_on, 8'hFF);
    ul_raw = 8'h41;
    tick(P_UL + 1);
    chk("R5 status only", status_word[13], 1);
    chk("R5 outputs stay on", drive_on, 8'hFF);
    ul_raw = 8'h00;

    // R6 thermal shutdown
    tsd_raw = 1'b1;
    tick(1);
    tsd_raw = 1'b0;
    tick(1);
    chk("R6 tsd flag", tsd_flag, 1);
    chk("R6 all off", drive_on, 8'h00);
    tick(3);
    chk("R6 held", drive_on, 8'h00);
    tick(P_GAP + 5);
    send(8'hFF, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0);
    tick(1);
    chk("R6 tsd cleared", tsd_flag, 0);
    chk("R6 drive back", drive_on, 8'hFF);

    done = 1;
    finish_up();
  end
endmodule